// File: doc/BRIEF.md
# Multi-Context Load-Reserve Monitor

This block keeps the load-reserve state for several hardware contexts that share one memory. Each context owns one reservation: an address granule and a valid flag. A locked load sets the requester's reservation. A conditional store consults that reservation and answers with a result code. The block also tells the memory side whether the store may be written.

Ordinary stores clear the reservations of all contexts whose granule matches the store address. Successful conditional stores and uncacheable conditional stores do the same. Granules are 16 bytes, so the low four address bits are ignored in every comparison.

Each context keeps a saturating count of consecutive failed conditional stores, which can be read through a select port. A one-cycle warning pulse fires on every WARN_EVERY-th consecutive failure of a context. Requests are taken one per cycle through a valid/ready pair. The response is registered and appears one cycle after acceptance.

Top module: `resv_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, `rsp_valid`, `mem_wr_en` and `warn_pulse` are low, every failure count reads 0, and no context holds a reservation, so a cached conditional store from any context fails.
- R2: An accepted locked load (`req_store`=0, `req_locked`=1) stores `req_addr[AW-1:4]` as the requester's reservation and sets its flag. Its response has `rsp_code`=0 and `mem_wr_en`=0.
- R3: A cached conditional store (`req_store`=1, `req_locked`=1, `req_uncached`=0) succeeds when the requester's flag is set and its granule equals `req_addr[AW-1:4]`. Success gives `rsp_code`=1 and `mem_wr_en`=1, and resets the requester's failure count to 0.
- R4: A cached conditional store that does not succeed gives `rsp_code`=0 and `mem_wr_en`=0. It clears the requester's flag and increments the requester's failure count, which saturates at 2^CNT_W-1.
- R5: An uncacheable conditional store (`req_store`=1, `req_locked`=1, `req_uncached`=1) skips the reservation check. It gives `rsp_code`=2 and `mem_wr_en`=1, and resets the requester's failure count.
- R6: An ordinary store (`req_store`=1, `req_locked`=0) gives `rsp_code`=0 and `mem_wr_en`=1. It clears the flag of every context whose granule matches the store address.
- R7: Any conditional store that writes memory (R3, R5) clears the flag of every context, the requester included, whose granule matches the store address. Contexts on other granules keep their reservations.
- R8: `warn_pulse` is high for one cycle, together with that failure's response, on each WARN_EVERY-th consecutive failure of a context. The phase restarts after any R3 or R5 store of that context.
- R9: `req_ready` is high whenever reset is low. Every accepted request produces exactly one cycle of `rsp_valid` one cycle later, and `rsp_valid` is low on cycles that follow no acceptance.
- R10: An accepted plain load (`req_store`=0, `req_locked`=0) gives `rsp_code`=0 and `mem_wr_en`=0, and changes no reservation and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_ctx | input | CW | Requesting context |
| req_addr | input | AW | Physical address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked attribute (load-reserve / conditional store) |
| req_uncached | input | 1 | Uncacheable attribute |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_code | output | 2 | 0 fail or none, 1 success, 2 uncacheable conditional |
| mem_wr_en | output | 1 | Store may be written to memory |
| warn_pulse | output | 1 | Failure-count warning |
| cnt_sel | input | CW | Context whose failure count is read |
| cnt_val | output | CNT_W | Failure count of the selected context |

## Verification
Reservation flags and granules are never visible directly. A lost, stale or wrongly shared reservation shows up only at the next conditional store from an affected context: `rsp_code` and `mem_wr_en` are wrong one cycle after that store is accepted. The bench therefore drives long mixed sequences on a few colliding granules, so that every flag is probed by a store soon after it changes. A wrong counter or phase shows on `cnt_val` at once, and on `warn_pulse` within WARN_EVERY failures.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int NCTX       = 4,
  parameter int AW         = 32,
  parameter int CNT_W      = 17,
  parameter int WARN_EVERY = 100000,
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int GW = AW - 4,
  localparam int PW = $clog2(WARN_EVERY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CW-1:0]    req_ctx,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_store,
  input  logic             req_locked,
  input  logic             req_uncached,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic             mem_wr_en,
  output logic             warn_pulse,
  input  logic [CW-1:0]    cnt_sel,
  output logic [CNT_W-1:0] cnt_val
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PW-1:0]    PH_LAST = PW'(WARN_EVERY - 1);

  logic [NCTX-1:0]  flag;
  logic [GW-1:0]    gran  [NCTX];
  logic [CNT_W-1:0] cnt   [NCTX];
  logic [PW-1:0]    phase [NCTX];
  logic [NCTX-1:0]  hit;

  logic [GW-1:0] req_g;
  logic acc, is_sc, sc_uc, sc_ok, sc_fail, do_write, own_hit, ll;

  assign req_ready = !rst;
  assign acc       = req_valid && req_ready;
  assign req_g     = req_addr[AW-1:4];

  for (genvar c = 0; c < NCTX; c++) begin : g_hit
    assign hit[c] = flag[c] && (gran[c] == req_g);
  end

  assign own_hit  = hit[req_ctx];
  assign ll       = !req_store && req_locked;
  assign is_sc    = req_store && req_locked;
  assign sc_uc    = is_sc && req_uncached;
  assign sc_ok    = is_sc && !req_uncached && own_hit;
  assign sc_fail  = is_sc && !req_uncached && !own_hit;
  assign do_write = req_store && !sc_fail;
  assign cnt_val  = cnt[cnt_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= 2'd0;
      mem_wr_en  <= 1'b0;
      warn_pulse <= 1'b0;
      flag       <= '0;
      for (int c = 0; c < NCTX; c++) begin
        gran[c]  <= '0;
        cnt[c]   <= '0;
        phase[c] <= '0;
      end
    end else begin
      rsp_valid  <= acc;
      mem_wr_en  <= acc && do_write;
      rsp_code   <= !acc ? 2'd0 : sc_uc ? 2'd2 : sc_ok ? 2'd1 : 2'd0;
      warn_pulse <= 1'b0;
      if (acc) begin
        if (do_write) begin
          for (int c = 0; c < NCTX; c++)
            if (hit[c]) flag[c] <= 1'b0;
        end
        if (ll) begin
          gran[req_ctx] <= req_g;
          flag[req_ctx] <= 1'b1;
        end
        if (sc_fail) begin
          flag[req_ctx] <= 1'b0;
          if (cnt[req_ctx] != CNT_MAX) cnt[req_ctx] <= cnt[req_ctx] + 1'b1;
          if (phase[req_ctx] == PH_LAST) begin
            phase[req_ctx] <= '0;
            warn_pulse     <= 1'b1;
          end else begin
            phase[req_ctx] <= phase[req_ctx] + 1'b1;
          end
        end
        if (sc_ok || sc_uc) begin
          cnt[req_ctx]   <= '0;
          phase[req_ctx] <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_store,
  input logic          req_locked,
  input logic          req_uncached,
  input logic          rsp_valid,
  input logic [1:0]    rsp_code,
  input logic          mem_wr_en,
  input logic          warn_pulse
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) !rst |-> req_ready); // R9
  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst) $past(acc) |-> rsp_valid); // R9
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) !$past(acc) |-> !rsp_valid && !mem_wr_en); // R9
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst) rsp_code != 2'd3); // R3
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst) $past(acc && !req_store) |-> !mem_wr_en && rsp_code == 2'd0); // R10
  AST_PLAIN_STORE_WRITES: assert property (@(posedge clk) disable iff (rst) $past(acc && req_store && !req_locked) |-> mem_wr_en && rsp_code == 2'd0); // R6
  AST_UNCACHED_SC_CODE: assert property (@(posedge clk) disable iff (rst) $past(acc && req_store && req_locked && req_uncached) |-> mem_wr_en && rsp_code == 2'd2); // R5
  AST_CACHED_SC_CONSISTENT: assert property (@(posedge clk) disable iff (rst) $past(acc && req_store && req_locked && !req_uncached) |-> mem_wr_en == (rsp_code == 2'd1)); // R4
  AST_WARN_ONLY_ON_FAIL: assert property (@(posedge clk) disable iff (rst) warn_pulse |-> rsp_valid && !mem_wr_en && rsp_code == 2'd0); // R8

endmodule

bind resv_monitor resv_monitor_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_store(req_store), .req_locked(req_locked), .req_uncached(req_uncached),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_wr_en(mem_wr_en),
  .warn_pulse(warn_pulse)
);

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
  localparam int NCTX = 4, AW = 12, CNT_W = 3, WARN = 3, CW = 2;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_store = 0, req_locked = 0, req_uncached = 0;
  logic [CW-1:0] req_ctx = '0, cnt_sel = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_wr_en, warn_pulse;
  logic [1:0] rsp_code;
  logic [CNT_W-1:0] cnt_val;

  always #10 clk = ~clk;

  resv_monitor #(.NCTX(NCTX), .AW(AW), .CNT_W(CNT_W), .WARN_EVERY(WARN)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_addr(req_addr), .req_store(req_store),
    .req_locked(req_locked), .req_uncached(req_uncached),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_wr_en(mem_wr_en),
    .warn_pulse(warn_pulse), .cnt_sel(cnt_sel), .cnt_val(cnt_val));

  int vectors = 0, fails = 0;
  bit m_flag [NCTX];
  int m_gran [NCTX];
  int m_cnt [NCTX];
  int m_ph [NCTX];
  int e_code, e_wr, e_warn, e_valid;
  string tag;

  task automatic chk(string t, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic check_counts(string t);
    for (int c = 0; c < NCTX; c++) begin
      cnt_sel = CW'(c);
      #1;
      chk(t, int'(cnt_val), m_cnt[c]);
    end
  endtask

  // Computes the expected response from the requirements and updates the model.
  task automatic apply(bit v, int ctx, int addr, bit st, bit lk, bit uc);
    int g;
    bit hit, fail, wr;
    g = addr >> 4;
    req_valid = v; req_ctx = CW'(ctx); req_addr = AW'(addr);
    req_store = st; req_locked = lk; req_uncached = uc;
    e_valid = v; e_code = 0; e_wr = 0; e_warn = 0; tag = "R9";
    if (v) begin
      hit  = m_flag[ctx] && m_gran[ctx] == g;
      fail = st && lk && !uc && !hit;
      wr   = st && !fail;
      if (!st && !lk) tag = "R10";
      if (!st && lk) tag = "R2";
      if (st && !lk) tag = "R6";
      if (st && lk && uc) begin tag = "R5"; e_code = 2; end
      if (st && lk && !uc && hit) begin tag = "R3"; e_code = 1; end
      if (fail) tag = "R4";
      e_wr = wr;
      if (wr)
        for (int c = 0; c < NCTX; c++)
          if (m_flag[c] && m_gran[c] == g) m_flag[c] = 0;
      if (!st && lk) begin m_gran[ctx] = g; m_flag[ctx] = 1; end
      if (fail) begin
        m_flag[ctx] = 0;
        if (m_cnt[ctx] < CMAX) m_cnt[ctx]++;
        if (m_ph[ctx] == WARN - 1) begin m_ph[ctx] = 0; e_warn = 1; end
        else m_ph[ctx]++;
      end
      if (st && lk && (uc || hit)) begin m_cnt[ctx] = 0; m_ph[ctx] = 0; end
    end
    @(negedge clk);
    chk("R9", rsp_valid, e_valid);
    chk(tag, rsp_code, e_code);
    chk(tag, mem_wr_en, e_wr);
    chk(e_warn ? "R8" : tag, warn_pulse, e_warn);
    check_counts(tag);
    chk("R9", req_ready, 1);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int c = 0; c < NCTX; c++) begin m_flag[c] = 0; m_gran[c] = 0; m_cnt[c] = 0; m_ph[c] = 0; end
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1", rsp_valid, 0);
    chk("R1", mem_wr_en, 0);
    chk("R1", warn_pulse, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", rsp_valid, 0);
    check_counts("R1");
    // R1: no reservation after reset
    for (int c = 0; c < NCTX; c++) apply(1, c, 16'h0040, 1, 1, 0);
    // R2/R3: reserve then succeed on same granule with other low bits
    apply(1, 0, 12'h120, 0, 1, 0);
    apply(1, 0, 12'h12F, 1, 1, 0);
    // R7: success clears own reservation
    apply(1, 0, 12'h120, 1, 1, 0);
    // R7: success by ctx1 clears ctx2 on same granule, ctx3 elsewhere keeps
    apply(1, 1, 12'h200, 0, 1, 0);
    apply(1, 2, 12'h205, 0, 1, 0);
    apply(1, 3, 12'h300, 0, 1, 0);
    apply(1, 1, 12'h20A, 1, 1, 0);
    apply(1, 2, 12'h200, 1, 1, 0);
    apply(1, 3, 12'h301, 1, 1, 0);
    // R6: ordinary store clears matching reservation
    apply(1, 0, 12'h400, 0, 1, 0);
    apply(1, 1, 12'h40C, 1, 0, 0);
    apply(1, 0, 12'h400, 1, 1, 0);
    // R10: plain load keeps reservation
    apply(1, 2, 12'h500, 0, 1, 0);
    apply(1, 2, 12'h500, 0, 0, 0);
    apply(1, 2, 12'h500, 1, 1, 0);
    // R5 / R8 / R4 saturation: repeated failures of ctx3
    for (int i = 0; i < 10; i++) apply(1, 3, 12'h700, 1, 1, 0);
    apply(1, 3, 12'h700, 1, 1, 1);
    for (int i = 0; i < 4; i++) apply(1, 3, 12'h700, 1, 1, 0);
    // R9: idle cycles
    apply(0, 0, 0, 1, 1, 0);
    apply(0, 1, 0, 0, 0, 0);
    // Sweep on a few colliding granules
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 4000; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      apply(lf[0] | lf[1], int'(lf[3:2]), int'({lf[5:4], lf[11:8]}) + 12'h800,
            lf[12], lf[13] | lf[14], lf[15] & lf[16]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule